// File: doc/BRIEF.md
# Arithmetic Condition Flag Generator

This unit holds the four condition flags of a processor datapath: negative, zero, carry and overflow. It updates them from the outcome of one data-processing operation per clock. The ALU presents its result, both operands, the adder carry-out, the shifter carry-out and a 2-bit class that says what kind of operation produced the result. When the set-flags input is high, the flags register loads new values on the rising edge. Each flag follows its own rule for the given class. When set-flags is low, the register keeps its contents.

The unit also decides whether an instruction should execute. A 4-bit condition selector is tested against the flags currently held in the register, and the result appears combinationally on `cond_pass`. The flag register is the only state. It has two named transitions on each edge: LOAD, taken when `set_flags` is high, and HOLD, taken otherwise. An asynchronous active-low reset puts the register in CLEAR, with all flags at zero.

Top module: `cond_flag_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first LOAD, `flags_q` is 4'b0000.
- R2: The layout of `flags_q` is {N, Z, C, V} (bit 3 down to bit 0). On a LOAD, N takes the most significant bit of `result`.
- R3: On a LOAD, Z becomes 1 exactly when every bit of `result` is 0.
- R4: For `op_class` 0 (add), a LOAD sets C to `add_cout` and sets V to 1 exactly when both operands have the same sign and the sign of `result` differs from it.
- R5: For `op_class` 1 (subtract or compare, result = a - b), a LOAD sets C to 1 when no borrow occurs (unsigned `opnd_a` >= `opnd_b`) and to 0 when a borrow occurs. V is set to 1 exactly when the operands differ in sign and the sign of `result` differs from that of `opnd_a`.
- R6: For `op_class` 2 (logical operation with shift), a LOAD sets C to `shift_cout` and keeps V. For a zero shift amount the ALU supplies the current C as `shift_cout`, so C stays unchanged.
- R7: For `op_class` 3 (other logical operation), a LOAD keeps both C and V, while N and Z still update.
- R8: When `set_flags` is low, all four flags keep their values on the clock edge (HOLD).
- R9: `cond_pass` depends only on the held flags and on `cond_sel`, with no clock delay. Codes 0 to 7 test a single flag: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear.
- R10: Codes 8 to 13 test combined flags: 8 C set and Z clear (unsigned higher), 9 C clear or Z set, 10 N equals V, 11 N differs from V, 12 Z clear and N equals V, 13 Z set or N differs from V.
- R11: Code 14 always passes and code 15 never passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| result | input | 32 | Result word produced by the ALU |
| opnd_a | input | 32 | First ALU operand |
| opnd_b | input | 32 | Second ALU operand (the subtrahend for class 1) |
| add_cout | input | 1 | Carry out of the adder's top bit, used for class 0 |
| shift_cout | input | 1 | Last bit shifted out by the shifter, used for class 2 |
| op_class | input | 2 | 0 add, 1 subtract/compare, 2 logical with shift, 3 other logical |
| set_flags | input | 1 | High: load the new flags on this edge |
| cond_sel | input | 4 | Condition code to evaluate |
| flags_q | output | 4 | Held flags {N, Z, C, V} |
| cond_pass | output | 1 | High when the selected condition holds for `flags_q` |

## Verification
The assertions assume that the ALU inputs are consistent with each other. For class 0, `result` and `add_cout` must be the true 32-bit sum and carry of the operands. For class 1, `result` must be `opnd_a - opnd_b`. The bench keeps to this by computing the result and the carry from the operands it drives, and it never presents a free-standing result under an arithmetic class. Only the shift and logical classes receive arbitrary result words and shifter carries. The zero-shift case is exercised by passing the model's current C as the shifter carry.

// File: rtl/cflag_pkg.sv
package cflag_pkg;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'd0,
        OPC_SUB   = 2'd1,
        OPC_SHLOG = 2'd2,
        OPC_LOGIC = 2'd3
    } opc_e;

    typedef enum logic [3:0] {
        CND_ZS = 4'd0,  CND_ZC = 4'd1,  CND_CS = 4'd2,  CND_CC = 4'd3,
        CND_NS = 4'd4,  CND_NC = 4'd5,  CND_VS = 4'd6,  CND_VC = 4'd7,
        CND_UH = 4'd8,  CND_UL = 4'd9,  CND_SG = 4'd10, CND_SL = 4'd11,
        CND_GT = 4'd12, CND_LE = 4'd13, CND_AL = 4'd14, CND_NV = 4'd15
    } cnd_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } flags_t;

    localparam int FLAG_N_BIT = 3;
    localparam int FLAG_Z_BIT = 2;
    localparam int FLAG_C_BIT = 1;
    localparam int FLAG_V_BIT = 0;

endpackage

// File: rtl/cflag_nzgen.sv
module cflag_nzgen #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res_i,
    output logic              neg_o,
    output logic              zero_o
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        neg_o  = res_i[MSB];
        zero_o = ~(|res_i);
    end
endmodule

// File: rtl/cflag_cvgen.sv
module cflag_cvgen
    import cflag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  opc_e              opc_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              res_msb_i,
    input  logic              add_cout_i,
    input  logic              sh_cout_i,
    input  logic              cur_c_i,
    input  logic              cur_v_i,
    output logic              nxt_c_o,
    output logic              nxt_v_o
);
    localparam int MSB = DATA_W - 1;

    logic no_borrow;
    logic add_ovf;
    logic sub_ovf;

    always_comb begin
        no_borrow = (a_i >= b_i);
        add_ovf   = (a_i[MSB] == b_i[MSB]) && (res_msb_i != a_i[MSB]);
        sub_ovf   = (a_i[MSB] != b_i[MSB]) && (res_msb_i != a_i[MSB]);
    end

    always_comb begin
        nxt_c_o = cur_c_i;
        nxt_v_o = cur_v_i;
        unique case (opc_i)
            OPC_ADD: begin
                nxt_c_o = add_cout_i;
                nxt_v_o = add_ovf;
            end
            OPC_SUB: begin
                nxt_c_o = no_borrow;
                nxt_v_o = sub_ovf;
            end
            OPC_SHLOG: begin
                nxt_c_o = sh_cout_i;
                nxt_v_o = cur_v_i;
            end
            OPC_LOGIC: begin
                nxt_c_o = cur_c_i;
                nxt_v_o = cur_v_i;
            end
            default: begin
                nxt_c_o = cur_c_i;
                nxt_v_o = cur_v_i;
            end
        endcase
    end
endmodule

// File: rtl/cflag_cond_eval.sv
module cflag_cond_eval
    import cflag_pkg::*;
(
    input  flags_t flg_i,
    input  cnd_e   cnd_i,
    output logic   pass_o
);
    logic n_eq_v;

    always_comb begin
        n_eq_v = (flg_i.neg == flg_i.ovf);
        pass_o = 1'b0;
        unique case (cnd_i)
            CND_ZS: pass_o = flg_i.zero;
            CND_ZC: pass_o = ~flg_i.zero;
            CND_CS: pass_o = flg_i.carry;
            CND_CC: pass_o = ~flg_i.carry;
            CND_NS: pass_o = flg_i.neg;
            CND_NC: pass_o = ~flg_i.neg;
            CND_VS: pass_o = flg_i.ovf;
            CND_VC: pass_o = ~flg_i.ovf;
            CND_UH: pass_o = flg_i.carry & ~flg_i.zero;
            CND_UL: pass_o = ~flg_i.carry | flg_i.zero;
            CND_SG: pass_o = n_eq_v;
            CND_SL: pass_o = ~n_eq_v;
            CND_GT: pass_o = ~flg_i.zero & n_eq_v;
            CND_LE: pass_o = flg_i.zero | ~n_eq_v;
            CND_AL: pass_o = 1'b1;
            CND_NV: pass_o = 1'b0;
            default: pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
    import cflag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] result,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              add_cout,
    input  logic              shift_cout,
    input  logic [1:0]        op_class,
    input  logic              set_flags,
    input  logic [3:0]        cond_sel,
    output logic [3:0]        flags_q,
    output logic              cond_pass
);
    localparam int MSB = DATA_W - 1;

    typedef enum logic [1:0] {
        UPD_CLEAR = 2'd0,
        UPD_HOLD  = 2'd1,
        UPD_LOAD  = 2'd2
    } upd_e;

    flags_t cur_q;
    flags_t nxt_load;
    flags_t nxt_d;
    upd_e   upd;
    logic   n_new;
    logic   z_new;
    logic   c_new;
    logic   v_new;

    cflag_nzgen #(.DATA_W(DATA_W)) u_nz (
        .res_i  (result),
        .neg_o  (n_new),
        .zero_o (z_new)
    );

    cflag_cvgen #(.DATA_W(DATA_W)) u_cv (
        .opc_i      (opc_e'(op_class)),
        .a_i        (opnd_a),
        .b_i        (opnd_b),
        .res_msb_i  (result[MSB]),
        .add_cout_i (add_cout),
        .sh_cout_i  (shift_cout),
        .cur_c_i    (cur_q.carry),
        .cur_v_i    (cur_q.ovf),
        .nxt_c_o    (c_new),
        .nxt_v_o    (v_new)
    );

    always_comb begin
        upd = set_flags ? UPD_LOAD : UPD_HOLD;
        nxt_load = '{neg: n_new, zero: z_new, carry: c_new, ovf: v_new};
        nxt_d = cur_q;
        unique case (upd)
            UPD_LOAD:  nxt_d = nxt_load;
            UPD_HOLD:  nxt_d = cur_q;
            UPD_CLEAR: nxt_d = '0;
            default:   nxt_d = cur_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    cflag_cond_eval u_cond (
        .flg_i  (cur_q),
        .cnd_i  (cnd_e'(cond_sel)),
        .pass_o (cond_pass)
    );

    always_comb begin
        flags_q = cur_q;
    end

    // R2
    n_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags |=> flags_q[FLAG_N_BIT] == $past(result[MSB]));

    // R3
    z_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags |=> flags_q[FLAG_Z_BIT] == ($past(result) == '0));

    // R4
    add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && op_class == 2'd0) |=> flags_q[FLAG_C_BIT] == $past(add_cout));

    // R4
    add_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && op_class == 2'd0 && opnd_a[MSB] == opnd_b[MSB]
         && result[MSB] != opnd_a[MSB]) |=> flags_q[FLAG_V_BIT]);

    // R5
    sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && op_class == 2'd1 && opnd_a < opnd_b) |=> !flags_q[FLAG_C_BIT]);

    // R6
    shift_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && op_class == 2'd2) |=>
            (flags_q[FLAG_C_BIT] == $past(shift_cout)) && $stable(flags_q[FLAG_V_BIT]));

    // R7
    logic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && op_class == 2'd3) |=> $stable(flags_q[FLAG_C_BIT:FLAG_V_BIT]));

    // R8
    no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags |=> $stable(flags_q));

    // R11
    always_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd14) |-> cond_pass);

    // R11
    never_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd15) |-> !cond_pass);

endmodule

// File: tb/tb_cond_flag_unit.sv
module tb_cond_flag_unit;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] result, opnd_a, opnd_b;
    logic         add_cout, shift_cout, set_flags;
    logic [1:0]   op_class;
    logic [3:0]   cond_sel;
    logic [3:0]   flags_q;
    logic         cond_pass;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] m_flags = 4'b0000;
    string c_tag = "R1";
    string v_tag = "R1";

    always #10 clk = ~clk;

    cond_flag_unit #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .result(result), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .add_cout(add_cout), .shift_cout(shift_cout),
        .op_class(op_class), .set_flags(set_flags), .cond_sel(cond_sel),
        .flags_q(flags_q), .cond_pass(cond_pass)
    );

    function automatic logic ref_cond(input logic [3:0] f, input logic [3:0] c);
        logic n, z, cy, v;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic cmp_bit(input string tag, input string what,
                           input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic check_now();
        string ctag;
        cmp_bit("R2", "N flag", flags_q[3], m_flags[3]);
        cmp_bit("R3", "Z flag", flags_q[2], m_flags[2]);
        cmp_bit(c_tag, "C flag", flags_q[1], m_flags[1]);
        cmp_bit(v_tag, "V flag", flags_q[0], m_flags[0]);
        if (cond_sel < 4'd8) ctag = "R9";
        else if (cond_sel < 4'd14) ctag = "R10";
        else ctag = "R11";
        cmp_bit(ctag, $sformatf("cond_pass code %0d", cond_sel),
                cond_pass, ref_cond(m_flags, cond_sel));
    endtask

    // drive one operation; model computes expected flags for the next edge
    task automatic drive(input logic [1:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [W-1:0] r_free,
                         input logic shc, input logic sf, input logic [3:0] cs);
        longint unsigned us;
        longint          ss;
        logic [W-1:0]    r;
        logic            co;
        logic            cn, vn;
        @(negedge clk);
        check_now();
        r = r_free; co = 1'b0; cn = m_flags[1]; vn = m_flags[0];
        if (op == 2'd0) begin
            us = longint'(a) + longint'(b);
            r  = us[W-1:0];
            co = us[W];
            ss = longint'($signed(a)) + longint'($signed(b));
            cn = co;
            vn = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
        end else if (op == 2'd1) begin
            r  = a - b;
            co = $urandom_range(0, 1);
            ss = longint'($signed(a)) - longint'($signed(b));
            cn = (a >= b);
            vn = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
        end else if (op == 2'd2) begin
            co = $urandom_range(0, 1);
            cn = shc;
        end else begin
            co = $urandom_range(0, 1);
        end
        opnd_a = a; opnd_b = b; result = r; add_cout = co; shift_cout = shc;
        op_class = op; set_flags = sf; cond_sel = cs;
        if (sf) begin
            m_flags = {r[W-1], (r == '0), cn, vn};
            case (op)
                2'd0: begin c_tag = "R4"; v_tag = "R4"; end
                2'd1: begin c_tag = "R5"; v_tag = "R5"; end
                2'd2: begin c_tag = "R6"; v_tag = "R6"; end
                default: begin c_tag = "R7"; v_tag = "R7"; end
            endcase
        end else begin
            c_tag = "R8"; v_tag = "R8";
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; result = '0; opnd_a = '0; opnd_b = '0; add_cout = 1'b0;
        shift_cout = 1'b0; op_class = 2'd0; set_flags = 1'b0; cond_sel = 4'd0;
        repeat (3) @(negedge clk);
        cmp_bit("R1", "flags in reset N", flags_q[3], 1'b0);
        cmp_bit("R1", "flags in reset Z", flags_q[2], 1'b0);
        cmp_bit("R1", "flags in reset C", flags_q[1], 1'b0);
        cmp_bit("R1", "flags in reset V", flags_q[0], 1'b0);
        rst_n = 1'b1;
        // directed corners
        drive(2'd0, 32'h7FFF_FFFF, 32'h0000_0001, '0, 1'b0, 1'b1, 4'd6);   // R4 overflow
        drive(2'd0, 32'hFFFF_FFFF, 32'h0000_0001, '0, 1'b0, 1'b1, 4'd0);   // R4 carry, zero
        drive(2'd1, 32'd5, 32'd5, '0, 1'b0, 1'b1, 4'd2);                   // R5 no borrow
        drive(2'd1, 32'd3, 32'd5, '0, 1'b0, 1'b1, 4'd3);                   // R5 borrow
        drive(2'd1, 32'h8000_0000, 32'd1, '0, 1'b0, 1'b1, 4'd11);          // R5 overflow
        drive(2'd3, '0, '0, 32'h0000_0000, 1'b1, 1'b1, 4'd8);              // R7 hold C,V
        drive(2'd2, '0, '0, 32'h8000_0010, 1'b1, 1'b1, 4'd4);              // R6 shift out 1
        drive(2'd2, '0, '0, 32'h0000_0001, m_flags[1], 1'b1, 4'd10);       // R6 zero shift
        drive(2'd0, 32'h8000_0000, 32'h8000_0000, '0, 1'b0, 1'b0, 4'd14);  // R8 no update
        drive(2'd1, 32'h1, 32'h2, '0, 1'b0, 1'b0, 4'd15);                  // R8 no update
        drive(2'd0, 32'h8000_0000, 32'h8000_0000, '0, 1'b0, 1'b1, 4'd12);  // R4 neg overflow
        drive(2'd3, '0, '0, 32'h1234_5678, 1'b0, 1'b1, 4'd13);
        // mixed stimulus sweeping every condition code
        for (int i = 0; i < 1600; i++) begin
            logic [W-1:0] a, b;
            logic [1:0]   op;
            a  = $urandom();
            b  = (i % 7 == 0) ? a : $urandom();
            if (i % 5 == 0) b = b ^ 32'h8000_0000;
            op = 2'($urandom_range(0, 3));
            drive(op, a, b, (i % 9 == 0) ? '0 : $urandom(),
                  (i % 4 == 0) ? m_flags[1] : 1'($urandom_range(0, 1)),
                  ($urandom_range(0, 3) != 0), 4'(i % 16));
        end
        @(negedge clk);
        check_now();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule